// File: doc/BRIEF.md
# Heterogeneous SIMD Processing-Element Group

This block is one processing-element group of a reconfigurable SIMD array. It holds four integer functional units. Each unit has an ALU, a small local register file and a result register. All four units share one multiplier and one scratchpad memory port. A configuration memory that is scheduled ahead of time supplies one operation word per unit in every cycle. Each word selects what the unit does and where both of its operands come from. The operand sources are the result registers of the group, the unit's own register file, an immediate field, and the matching unit in the groups on either side. No selection is made by hardware at run time.

A mode register chooses between two ways of running. In lane mode, unit 0's word is the only program. Unit *k* runs the same word *k* cycles after unit 0 does, so one multiply in the program reaches the shared multiplier one lane at a time. In wide-issue mode, the four units form one logical lane and each unit runs its own word. If two units ask for the multiplier, or two ask for the memory port, in the same cycle, the lowest-numbered unit is served and a sticky flag records that the schedule was wrong. The result registers also feed the adjacent groups.

Top module: `hsimd_group`

## Requirements
- R1: After reset every result register reads 0, both conflict flags read 0 and the mode reads 0 (lane mode).
- R2: The operation code is held in bits [23:21] of a word: 0 NOP, 1 ADD, 2 SUB (A minus B), 3 AND, 4 XOR, 5 MUL, 6 LOAD, 7 STORE. An ALU result is stored in the unit's result register one cycle after issue, and 32-bit arithmetic wraps.
- R3: Operand A is selected by bits [20:18] and operand B by bits [17:15]. Codes 0 to 3 pick a result register, 4 picks the unit's register file entry addressed by bits [14:12], 5 picks the zero-extended immediate in bits [7:0], 6 picks the left-neighbour input and 7 picks the right-neighbour input for that unit. In wide mode, codes 0 to 3 name units 0 to 3 directly.
- R4: When bit 11 is set, a unit that executes an operation writes its new result into its register file entry addressed by bits [10:8]. The value can be read back through source code 4 on a later cycle.
- R5: A granted MUL stores the low 32 bits of A times B in the result register one cycle after issue.
- R6: A STORE writes operand B to scratchpad word A[7:0]. A granted LOAD stores scratchpad word A[7:0] in the result register one cycle after issue.
- R7: When more than one unit issues MUL in a cycle, only the lowest-numbered one executes and the others keep their result and register file. The multiply conflict flag is set and stays set until reset.
- R8: When more than one unit issues LOAD or STORE in a cycle, only the lowest-numbered one executes. The memory conflict flag is set and stays set until reset.
- R9: In lane mode (mode 0), unit k executes the word presented to unit 0 exactly k cycles earlier, and the words on units 1 to 3 are ignored. Source codes 0 to 3 then mean unit (k + code) mod 4, so code 0 is the lane's own result.
- R10: A mode write takes effect only in a cycle when no unit executes a non-NOP word and none is still pending in the lane stagger. Otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr_i | input | 1 | Mode write request |
| mode_req_i | input | 1 | Requested mode: 0 lane, 1 wide-issue |
| op_i | input | 4x24 | Operation word per unit |
| nbl_i | input | 4x32 | Data from the matching units of the left group |
| nbr_i | input | 4x32 | Data from the matching units of the right group |
| res_o | output | 4x32 | Result registers, also sent to both neighbour groups |
| mode_o | output | 1 | Current mode |
| mul_conflict_o | output | 1 | Sticky flag for a multiplier conflict |
| mem_conflict_o | output | 1 | Sticky flag for a memory-port conflict |

## Verification
Directed words test each operand source on its own: the neighbour inputs, the register file round trip, a store followed by a load, and the wrap of a multiply of all-ones. Each word has a known constant result, so a source selected wrongly shows up as a wrong value. Clashing multiplies and clashing memory accesses in the same cycle show whether the lowest unit wins while the losers hold their values. Random words with random neighbour data run in both modes, with mode writes attempted while units are busy and while they are idle. This separates a correct lane stagger and source rotation from a design that just runs every unit's own word.

// File: rtl/hsimd_pkg.sv
package hsimd_pkg;
  localparam int DW    = 32;
  localparam int RF_AW = 3;
  localparam int IMM_W = 8;
  localparam int SEL_W = 3;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_AND = 3'd3,
    OP_XOR = 3'd4,
    OP_MUL = 3'd5,
    OP_LD  = 3'd6,
    OP_ST  = 3'd7
  } opc_e;

  typedef struct packed {
    opc_e             opc;
    logic [SEL_W-1:0] sel_a;
    logic [SEL_W-1:0] sel_b;
    logic [RF_AW-1:0] rf_ra;
    logic             rf_we;
    logic [RF_AW-1:0] rf_wa;
    logic [IMM_W-1:0] imm;
  } op_t;

  localparam int OP_W = $bits(op_t);

  localparam logic [SEL_W-1:0] SRC_RF  = 3'd4;
  localparam logic [SEL_W-1:0] SRC_IMM = 3'd5;
  localparam logic [SEL_W-1:0] SRC_NBL = 3'd6;
  localparam logic [SEL_W-1:0] SRC_NBR = 3'd7;
endpackage

// File: rtl/hsimd_xbar.sv
module hsimd_xbar
  import hsimd_pkg::*;
#(
  parameter int NFU = 4
) (
  input  logic                      lane_mode_i,
  input  logic [NFU-1:0][DW-1:0]    res_i,
  input  logic [NFU-1:0][DW-1:0]    rf_i,
  input  logic [NFU-1:0][DW-1:0]    imm_i,
  input  logic [NFU-1:0][DW-1:0]    nbl_i,
  input  logic [NFU-1:0][DW-1:0]    nbr_i,
  input  logic [NFU-1:0][SEL_W-1:0] sela_i,
  input  logic [NFU-1:0][SEL_W-1:0] selb_i,
  output logic [NFU-1:0][DW-1:0]    opa_o,
  output logic [NFU-1:0][DW-1:0]    opb_o
);
  localparam int NSRC = 1 << SEL_W;

  for (genvar d = 0; d < NFU; d++) begin : g_dst
    logic [NSRC-1:0][DW-1:0] src;

    // result-register sources: lane mode rotates so code 0 is the lane itself
    for (genvar k = 0; k < 4; k++) begin : g_res
      localparam int ABS = k % NFU;
      localparam int ROT = (d + k) % NFU;
      assign src[k] = lane_mode_i ? res_i[ROT] : res_i[ABS];
    end
    assign src[SRC_RF]  = rf_i[d];
    assign src[SRC_IMM] = imm_i[d];
    assign src[SRC_NBL] = nbl_i[d];
    assign src[SRC_NBR] = nbr_i[d];

    assign opa_o[d] = src[sela_i[d]];
    assign opb_o[d] = src[selb_i[d]];
  end
endmodule

// File: rtl/hsimd_fu.sv
module hsimd_fu
  import hsimd_pkg::*;
#(
  parameter int RF_DEPTH = 1 << RF_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_t           op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic          mul_gnt_i,
  input  logic          mem_gnt_i,
  input  logic [DW-1:0] mul_p_i,
  input  logic [DW-1:0] mem_rd_i,
  output logic          mul_req_o,
  output logic          mem_req_o,
  output logic          st_req_o,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] rf_rd_o
);
  logic [DW-1:0] res_q;
  logic [DW-1:0] res_d;
  logic          res_en;
  logic          rf_en;
  logic [DW-1:0] rf_q [RF_DEPTH];

  assign mul_req_o = (op_i.opc == OP_MUL);
  assign st_req_o  = (op_i.opc == OP_ST);
  assign mem_req_o = (op_i.opc == OP_LD) || (op_i.opc == OP_ST);

  always_comb begin
    res_en = 1'b0;
    res_d  = res_q;
    case (op_i.opc)
      OP_ADD: begin res_en = 1'b1;      res_d = opa_i + opb_i; end
      OP_SUB: begin res_en = 1'b1;      res_d = opa_i - opb_i; end
      OP_AND: begin res_en = 1'b1;      res_d = opa_i & opb_i; end
      OP_XOR: begin res_en = 1'b1;      res_d = opa_i ^ opb_i; end
      OP_MUL: begin res_en = mul_gnt_i; res_d = mul_p_i;       end
      OP_LD:  begin res_en = mem_gnt_i; res_d = mem_rd_i;      end
      default: ;
    endcase
  end

  assign rf_en = res_en && op_i.rf_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rf_en) begin
      rf_q[op_i.rf_wa] <= res_d;
    end
  end

  assign rf_rd_o = rf_q[op_i.rf_ra];
  assign res_o   = res_q;
endmodule

// File: rtl/hsimd_shared.sv
module hsimd_shared
  import hsimd_pkg::*;
#(
  parameter int NFU       = 4,
  parameter int MEM_DEPTH = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NFU-1:0]         mul_req_i,
  input  logic [NFU-1:0]         mem_req_i,
  input  logic [NFU-1:0]         st_req_i,
  input  logic [NFU-1:0][DW-1:0] opa_i,
  input  logic [NFU-1:0][DW-1:0] opb_i,
  output logic [NFU-1:0]         mul_gnt_o,
  output logic [NFU-1:0]         mem_gnt_o,
  output logic [DW-1:0]          mul_p_o,
  output logic [DW-1:0]          mem_rd_o,
  output logic                   mul_conflict_o,
  output logic                   mem_conflict_o
);
  localparam int MEM_AW = $clog2(MEM_DEPTH);

  logic [DW-1:0]     mem_q [MEM_DEPTH];
  logic [DW-1:0]     mul_a, mul_b, mem_a, mem_b;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_we;
  logic              mul_multi, mem_multi;
  logic              mul_conf_q, mul_conf_d, mem_conf_q, mem_conf_d;

  // fixed priority: the lowest-numbered requester wins
  always_comb begin
    mul_gnt_o = '0;
    mem_gnt_o = '0;
    for (int u = NFU - 1; u >= 0; u--) begin
      if (mul_req_i[u]) begin
        mul_gnt_o    = '0;
        mul_gnt_o[u] = 1'b1;
      end
      if (mem_req_i[u]) begin
        mem_gnt_o    = '0;
        mem_gnt_o[u] = 1'b1;
      end
    end
  end

  always_comb begin
    mul_a = '0;
    mul_b = '0;
    mem_a = '0;
    mem_b = '0;
    for (int u = 0; u < NFU; u++) begin
      if (mul_gnt_o[u]) begin
        mul_a = opa_i[u];
        mul_b = opb_i[u];
      end
      if (mem_gnt_o[u]) begin
        mem_a = opa_i[u];
        mem_b = opb_i[u];
      end
    end
  end

  assign mul_p_o  = mul_a * mul_b;
  assign mem_addr = mem_a[MEM_AW-1:0];
  assign mem_we   = |(mem_gnt_o & st_req_i);
  assign mem_rd_o = mem_q[mem_addr];

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem_q[mem_addr] <= mem_b;
    end
  end

  assign mul_multi  = (mul_req_i & (mul_req_i - 1'b1)) != '0;
  assign mem_multi  = (mem_req_i & (mem_req_i - 1'b1)) != '0;
  assign mul_conf_d = mul_conf_q | mul_multi;
  assign mem_conf_d = mem_conf_q | mem_multi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mul_conf_q <= 1'b0;
      mem_conf_q <= 1'b0;
    end else begin
      mul_conf_q <= mul_conf_d;
      mem_conf_q <= mem_conf_d;
    end
  end

  assign mul_conflict_o = mul_conf_q;
  assign mem_conflict_o = mem_conf_q;

  // R7
  mul_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_conflict_o |=> mul_conflict_o);
  // R7
  mul_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mul_req_i) > 1) |=> mul_conflict_o);
  // R8
  mem_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_conflict_o |=> mem_conflict_o);
  // R8
  mem_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mem_req_i) > 1) |=> mem_conflict_o);
endmodule

// File: rtl/hsimd_group.sv
module hsimd_group
  import hsimd_pkg::*;
#(
  parameter int NFU       = 4,
  parameter int MEM_DEPTH = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_wr_i,
  input  logic                   mode_req_i,
  input  logic [NFU-1:0][OP_W-1:0] op_i,
  input  logic [NFU-1:0][DW-1:0] nbl_i,
  input  logic [NFU-1:0][DW-1:0] nbr_i,
  output logic [NFU-1:0][DW-1:0] res_o,
  output logic                   mode_o,
  output logic                   mul_conflict_o,
  output logic                   mem_conflict_o
);
  logic mode_q, mode_d, lane_mode, idle;
  op_t  dly_q [1:NFU-1];
  op_t  dly_d [1:NFU-1];
  op_t  eff   [NFU];

  logic [NFU-1:0][DW-1:0]    res, rf_rd, imm_ext, opa, opb;
  logic [NFU-1:0][SEL_W-1:0] sela, selb;
  logic [NFU-1:0]            mul_req, mem_req, st_req, mul_gnt, mem_gnt;
  logic [DW-1:0]             mul_p, mem_rd;

  assign lane_mode = ~mode_q;

  // lane stagger: stage k holds unit 0's word from k cycles ago
  always_comb begin
    dly_d[1] = lane_mode ? op_t'(op_i[0]) : '0;
    for (int k = 2; k < NFU; k++) begin
      dly_d[k] = dly_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k < NFU; k++) dly_q[k] <= '0;
    end else begin
      for (int k = 1; k < NFU; k++) dly_q[k] <= dly_d[k];
    end
  end

  for (genvar g = 0; g < NFU; g++) begin : g_eff
    if (g == 0) begin : g_head
      assign eff[g] = op_t'(op_i[0]);
    end else begin : g_tail
      assign eff[g] = lane_mode ? dly_q[g] : op_t'(op_i[g]);
    end
    assign imm_ext[g] = DW'(eff[g].imm);
    assign sela[g]    = eff[g].sel_a;
    assign selb[g]    = eff[g].sel_b;
  end

  always_comb begin
    idle = 1'b1;
    for (int u = 0; u < NFU; u++) begin
      if (eff[u].opc != OP_NOP) idle = 1'b0;
    end
    for (int k = 1; k < NFU; k++) begin
      if (dly_q[k].opc != OP_NOP) idle = 1'b0;
    end
  end

  assign mode_d = (mode_wr_i && idle) ? mode_req_i : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
    end
  end

  hsimd_xbar #(.NFU(NFU)) u_xbar (
    .lane_mode_i (lane_mode),
    .res_i       (res),
    .rf_i        (rf_rd),
    .imm_i       (imm_ext),
    .nbl_i       (nbl_i),
    .nbr_i       (nbr_i),
    .sela_i      (sela),
    .selb_i      (selb),
    .opa_o       (opa),
    .opb_o       (opb)
  );

  for (genvar g = 0; g < NFU; g++) begin : g_fu
    hsimd_fu u_fu (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_i      (eff[g]),
      .opa_i     (opa[g]),
      .opb_i     (opb[g]),
      .mul_gnt_i (mul_gnt[g]),
      .mem_gnt_i (mem_gnt[g]),
      .mul_p_i   (mul_p),
      .mem_rd_i  (mem_rd),
      .mul_req_o (mul_req[g]),
      .mem_req_o (mem_req[g]),
      .st_req_o  (st_req[g]),
      .res_o     (res[g]),
      .rf_rd_o   (rf_rd[g])
    );
  end

  hsimd_shared #(.NFU(NFU), .MEM_DEPTH(MEM_DEPTH)) u_shared (
    .clk            (clk),
    .rst_n          (rst_n),
    .mul_req_i      (mul_req),
    .mem_req_i      (mem_req),
    .st_req_i       (st_req),
    .opa_i          (opa),
    .opb_i          (opb),
    .mul_gnt_o      (mul_gnt),
    .mem_gnt_o      (mem_gnt),
    .mul_p_o        (mul_p),
    .mem_rd_o       (mem_rd),
    .mul_conflict_o (mul_conflict_o),
    .mem_conflict_o (mem_conflict_o)
  );

  assign res_o  = res;
  assign mode_o = mode_q;

  // R10
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(idle));
endmodule

// File: tb/hsimd_group_tb_top.sv
`timescale 1ns/1ps
module hsimd_group_tb_top;
  import hsimd_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_wr, mode_req;
  logic [3:0][OP_W-1:0] op_in;
  logic [3:0][31:0] nbl, nbr, res_o;
  logic mode_o, mulc, memc;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  hsimd_group dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr_i(mode_wr), .mode_req_i(mode_req),
    .op_i(op_in), .nbl_i(nbl), .nbr_i(nbr), .res_o(res_o), .mode_o(mode_o),
    .mul_conflict_o(mulc), .mem_conflict_o(memc)
  );

  // reference state
  op_t         m_dly [1:3];
  logic [31:0] m_res [4];
  logic [31:0] m_rf  [4][8];
  logic [31:0] m_mem [256];
  logic        m_mode, m_mulc, m_memc;

  function automatic op_t mk(opc_e o, int sa, int sb, int ra, int we, int wa, int imm);
    op_t t;
    t.opc = o; t.sel_a = 3'(sa); t.sel_b = 3'(sb); t.rf_ra = 3'(ra);
    t.rf_we = 1'(we); t.rf_wa = 3'(wa); t.imm = 8'(imm);
    return t;
  endfunction

  function automatic logic [31:0] src_val(int u, logic [2:0] s, op_t o);
    case (s)
      3'd4: return m_rf[u][o.rf_ra];
      3'd5: return {24'd0, o.imm};
      3'd6: return nbl[u];
      3'd7: return nbr[u];
      default: return m_res[m_mode ? int'(s) : (u + int'(s)) % 4];
    endcase
  endfunction

  task automatic model_step();
    op_t e [4];
    logic [31:0] a [4], b [4], nr [4];
    logic en [4];
    int mg = -1, dg = -1, nm = 0, nd = 0;
    logic idle = 1'b1;
    for (int u = 0; u < 4; u++) e[u] = (!m_mode && u > 0) ? m_dly[u] : op_t'(op_in[u]);
    for (int u = 0; u < 4; u++) begin
      a[u] = src_val(u, e[u].sel_a, e[u]);
      b[u] = src_val(u, e[u].sel_b, e[u]);
      if (e[u].opc == OP_MUL) begin nm++; if (mg < 0) mg = u; end
      if (e[u].opc == OP_LD || e[u].opc == OP_ST) begin nd++; if (dg < 0) dg = u; end
      if (e[u].opc != OP_NOP) idle = 1'b0;
    end
    for (int k = 1; k < 4; k++) if (m_dly[k].opc != OP_NOP) idle = 1'b0;
    for (int u = 0; u < 4; u++) begin
      en[u] = 1'b0; nr[u] = m_res[u];
      case (e[u].opc)
        OP_ADD: begin en[u] = 1; nr[u] = a[u] + b[u]; end
        OP_SUB: begin en[u] = 1; nr[u] = a[u] - b[u]; end
        OP_AND: begin en[u] = 1; nr[u] = a[u] & b[u]; end
        OP_XOR: begin en[u] = 1; nr[u] = a[u] ^ b[u]; end
        OP_MUL: if (mg == u) begin en[u] = 1; nr[u] = a[u] * b[u]; end
        OP_LD:  if (dg == u) begin en[u] = 1; nr[u] = m_mem[a[u][7:0]]; end
        default: ;
      endcase
    end
    for (int u = 0; u < 4; u++) if (en[u]) begin
      m_res[u] = nr[u];
      if (e[u].rf_we) m_rf[u][e[u].rf_wa] = nr[u];
    end
    if (dg >= 0 && e[dg].opc == OP_ST) m_mem[a[dg][7:0]] = b[dg];
    m_mulc = m_mulc | (nm > 1);
    m_memc = m_memc | (nd > 1);
    m_dly[3] = m_dly[2];
    m_dly[2] = m_dly[1];
    m_dly[1] = m_mode ? op_t'('0) : op_t'(op_in[0]);
    if (mode_wr && idle) m_mode = mode_req;
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    for (int u = 0; u < 4; u++) chk(tag, $sformatf("res%0d", u), res_o[u], m_res[u]);
    chk("R10", "mode", {31'd0, mode_o}, {31'd0, m_mode});
    chk("R7", "mul flag", {31'd0, mulc}, {31'd0, m_mulc});
    chk("R8", "mem flag", {31'd0, memc}, {31'd0, m_memc});
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic nops();
    for (int u = 0; u < 4; u++) op_in[u] = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    void'($urandom(32'd20250611));
    rst_n = 1'b0; mode_wr = 0; mode_req = 0; nops(); nbl = '0; nbr = '0;
    for (int u = 0; u < 4; u++) begin
      m_res[u] = '0;
      for (int r = 0; r < 8; r++) m_rf[u][r] = '0;
    end
    for (int k = 1; k < 4; k++) m_dly[k] = '0;
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    m_mode = 0; m_mulc = 0; m_memc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int u = 0; u < 4; u++) chk("R1", "reset res", res_o[u], 32'd0);
    chk("R1", "reset mode", {31'd0, mode_o}, 32'd0);
    chk("R1", "reset flags", {30'd0, mulc, memc}, 32'd0);

    // R10 idle mode write into wide mode
    mode_wr = 1; mode_req = 1; step("R10");
    chk("R10", "wide accepted", {31'd0, mode_o}, 32'd1);
    mode_wr = 0;

    // R4 register file fill in wide mode
    for (int r = 0; r < 8; r++) begin
      for (int u = 0; u < 4; u++) op_in[u] = mk(OP_ADD, 5, 5, 0, 1, r, 16*u + r);
      step("R4");
    end
    // R6 scratchpad fill: word i holds i
    nops();
    for (int i = 0; i < 256; i++) begin
      op_in[0] = mk(OP_ST, 5, 5, 0, 0, 0, i);
      step("R6");
    end
    nops();

    // R3 neighbour sources
    nbl[1] = 32'd100; nbr[1] = 32'd23;
    op_in[1] = mk(OP_ADD, 6, 7, 0, 0, 0, 0); step("R3");
    chk("R3", "nbl+nbr", res_o[1], 32'd123);
    // R2 subtract wraps
    nops(); nbl[0] = 32'd1;
    op_in[0] = mk(OP_SUB, 5, 6, 0, 0, 0, 0); step("R2");
    chk("R2", "0-1 wraps", res_o[0], 32'hFFFF_FFFF);
    // R5 multiply low word
    nops(); op_in[1] = mk(OP_MUL, 0, 0, 0, 0, 0, 0); step("R5");
    chk("R5", "all-ones squared", res_o[1], 32'd1);
    // R4 write then read back
    nops(); op_in[2] = mk(OP_ADD, 5, 5, 0, 1, 5, 20); step("R4");
    op_in[2] = mk(OP_ADD, 4, 5, 5, 0, 0, 2); step("R4");
    chk("R4", "rf readback", res_o[2], 32'd42);
    // R6 store then load
    nops(); op_in[3] = mk(OP_ST, 5, 2, 0, 0, 0, 77); step("R6");
    op_in[3] = mk(OP_LD, 5, 5, 0, 0, 0, 77); step("R6");
    chk("R6", "load after store", res_o[3], 32'd42);
    // R7 two multiplies
    nops(); hold = res_o[2];
    op_in[1] = mk(OP_MUL, 0, 5, 0, 0, 0, 3);
    op_in[2] = mk(OP_MUL, 0, 5, 0, 1, 6, 3); step("R7");
    chk("R7", "winner", res_o[1], 32'hFFFF_FFFD);
    chk("R7", "loser holds", res_o[2], hold);
    chk("R7", "flag set", {31'd0, mulc}, 32'd1);
    nops(); step("R7");
    chk("R7", "flag sticky", {31'd0, mulc}, 32'd1);
    // R8 two loads
    hold = res_o[3];
    op_in[0] = mk(OP_LD, 5, 5, 0, 0, 0, 5);
    op_in[3] = mk(OP_LD, 5, 5, 0, 0, 0, 9); step("R8");
    chk("R8", "winner", res_o[0], 32'd5);
    chk("R8", "loser holds", res_o[3], hold);
    chk("R8", "flag set", {31'd0, memc}, 32'd1);
    // R10 write while busy ignored
    nops(); mode_wr = 1; mode_req = 0;
    op_in[0] = mk(OP_ADD, 5, 5, 0, 0, 0, 1); step("R10");
    chk("R10", "busy write ignored", {31'd0, mode_o}, 32'd1);
    nops(); step("R10");
    chk("R10", "idle write to lane", {31'd0, mode_o}, 32'd0);
    mode_wr = 0;

    // R9 stagger in lane mode
    for (int u = 1; u < 4; u++) op_in[u] = mk(OP_XOR, 5, 5, 0, 0, 0, 0);
    op_in[0] = mk(OP_ADD, 5, 5, 0, 0, 0, 7); step("R9");
    op_in[0] = '0;
    chk("R9", "lane0 at 1", res_o[0], 32'd14);
    hold = res_o[3];
    step("R9"); chk("R9", "lane1 at 2", res_o[1], 32'd14);
    step("R9"); chk("R9", "lane2 at 3", res_o[2], 32'd14);
    chk("R9", "lane3 not yet", res_o[3], hold);
    step("R9"); chk("R9", "lane3 at 4", res_o[3], 32'd14);
    // R9 rotated source: code 0 is the lane's own result
    op_in[0] = mk(OP_ADD, 0, 5, 0, 0, 0, 1); step("R9");
    nops(); repeat (3) step("R9");
    for (int u = 0; u < 4; u++) chk("R9", "own plus one", res_o[u], 32'd15);

    // random bursts in both modes
    for (int burst = 0; burst < 40; burst++) begin
      int len = 20 + int'($urandom % 40);
      for (int c = 0; c < len; c++) begin
        for (int u = 0; u < 4; u++) begin
          op_in[u] = OP_W'($urandom);
          nbl[u] = $urandom; nbr[u] = $urandom;
        end
        mode_wr = ($urandom % 16) == 0; mode_req = $urandom;
        step(m_mode ? "R2" : "R9");
      end
      nops(); mode_wr = 0;
      repeat (4) step("R10");
      mode_wr = 1; mode_req = ~m_mode; step("R10");
      mode_wr = 0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule